// File: doc/BRIEF.md
# Tearing-Effect Sync Detector

This block watches the single tearing-effect line that a display controller drives back to its host. Horizontal and vertical syncs share that one wire. The block tells them apart by how long each pulse lasts. It keeps a count of the lines seen since the most recent vertical sync. When the programmed condition is met, it raises a one-cycle match strobe. Downstream logic treats that strobe as the signal to release one pending frame transfer. Using it this way keeps screen updates from tearing.

All thresholds are given in clock ticks:
- The horizontal threshold is programmed as ticks minus one, so it can reach at most 8 ticks.
- The vertical threshold is programmed in steps of 8 ticks, minus one.

Each sync kind has its own polarity invert. The pin passes through a synchronizer before it is measured.

Top module: `tesync_detector`

## Requirements
- R1: While reset is high, and in the cycles after it falls before any sync has been seen, `match_o` is low.
- R2: A pulse shorter than `hs_width_cfg+1` ticks is ignored. It does not advance the line count and it never produces a match.
- R3: A pulse at least `(vs_width_cfg+1)*8` ticks long is a vertical sync. It sets the line count to 0.
- R4: A pulse at least `hs_width_cfg+1` ticks long but shorter than the vertical threshold is a horizontal sync. It adds one to the line count.
- R5: When `hs_invert` is 1, the horizontal pulse is measured while the pin is low. When `vs_invert` is 1, the vertical pulse is measured while the pin is low. With an invert at 0, the pulse is measured while the pin is high.
- R6: With `te_mode` = 2'b11 (vertical only), every vertical sync produces exactly one match. Horizontal syncs produce none.
- R7: With `te_mode` = 2'b10 (line match), a sync produces a match when the resulting line count equals `te_line`. The count after a vertical sync is 0, and each horizontal sync adds 1.
- R8: With `te_mode` = 2'b00 or 2'b01, no match is ever produced.
- R9: While `te_en` is low, no match is produced and the line count and pulse measurement are cleared. A pulse seen while disabled has no effect after re-enabling.
- R10: Each match is high for exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| te_en | input | 1 | Enables the detector logic |
| te_mode | input | 2 | 00/01 off, 10 line match, 11 vertical only |
| te_line | input | 11 | Target line count for line-match mode |
| hs_width_cfg | input | 3 | Horizontal threshold, ticks minus one |
| vs_width_cfg | input | 12 | Vertical threshold, units of 8 ticks minus one |
| hs_invert | input | 1 | Horizontal pulse active low when 1 |
| vs_invert | input | 1 | Vertical pulse active low when 1 |
| te_pin | input | 1 | Asynchronous tearing-effect input |
| match_o | output | 1 | One-cycle match strobe |

## Verification
The assertions check the following on every cycle:
- the match strobe lasts exactly one cycle;
- a disabled detector or an off mode never strobes;
- every vertical sync in vertical-only mode is followed by a strobe;
- a vertical sync clears the line count;
- a horizontal sync advances the line count by one.

Some behaviours can only be shown by the bench's pulse sequences:
- the exact width boundaries at which a pulse is ignored, counted as a line or taken as a vertical sync;
- the polarity inversion;
- which target lines match after a given number of horizontal syncs;
- whether a disable clears the line count.

// File: rtl/tesync_pkg.sv
package tesync_pkg;

    localparam int HS_CFG_W = 3;
    localparam int VS_CFG_W = 12;
    localparam int LINE_W   = 11;
    localparam int RUN_W    = VS_CFG_W + 4;

    typedef enum logic [1:0] {
        TE_MODE_OFF  = 2'b00,
        TE_MODE_RSVD = 2'b01,
        TE_MODE_LINE = 2'b10,
        TE_MODE_VS   = 2'b11
    } te_mode_e;

    typedef struct packed {
        logic             done;
        logic [RUN_W-1:0] len;
    } run_meas_t;

    typedef struct packed {
        logic hs;
        logic vs;
    } sync_evt_t;

    function automatic logic [RUN_W-1:0] hs_limit(input logic [HS_CFG_W-1:0] cfg);
        return RUN_W'(cfg) + RUN_W'(1);
    endfunction

    function automatic logic [RUN_W-1:0] vs_limit(input logic [VS_CFG_W-1:0] cfg);
        return (RUN_W'(cfg) + RUN_W'(1)) << 3;
    endfunction

endpackage

// File: rtl/tesync_input_sync.sv
module tesync_input_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/tesync_run_meter.sv
module tesync_run_meter
    import tesync_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      level,
    output run_meas_t meas
);
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    logic [RUN_W-1:0] run_q;
    logic             prev_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            run_q  <= '0;
            prev_q <= 1'b0;
            meas   <= '0;
        end else begin
            prev_q <= level;
            if (level) run_q <= (run_q == RUN_MAX) ? run_q : run_q + RUN_W'(1);
            else       run_q <= '0;
            meas.done <= prev_q && !level;
            meas.len  <= run_q;
        end
    end

    // R2
    nonzero_run_chk: assert property (@(posedge clk) disable iff (rst)
        meas.done |-> (meas.len != '0));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        meas.done |=> !meas.done);

endmodule

// File: rtl/tesync_classifier.sv
module tesync_classifier
    import tesync_pkg::*;
(
    input  run_meas_t             hs_meas,
    input  run_meas_t             vs_meas,
    input  logic [HS_CFG_W-1:0]   hs_cfg,
    input  logic [VS_CFG_W-1:0]   vs_cfg,
    output sync_evt_t             evt
);
    logic [RUN_W-1:0] hs_lim;
    logic [RUN_W-1:0] vs_lim;

    always_comb begin
        hs_lim = hs_limit(hs_cfg);
        vs_lim = vs_limit(vs_cfg);
        evt.vs = vs_meas.done && (vs_meas.len >= vs_lim);
        evt.hs = hs_meas.done && (hs_meas.len >= hs_lim)
                 && (hs_meas.len < vs_lim) && !evt.vs;
    end

endmodule

// File: rtl/tesync_line_tracker.sv
module tesync_line_tracker
    import tesync_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  te_mode_e          mode,
    input  logic [LINE_W-1:0] target,
    input  sync_evt_t         evt,
    output logic              match
);
    localparam logic [LINE_W-1:0] LINE_MAX = '1;

    logic [LINE_W-1:0] line_q;
    logic [LINE_W-1:0] line_nx;
    logic              hit;

    always_comb begin
        if (evt.vs)                          line_nx = '0;
        else if (evt.hs && line_q != LINE_MAX) line_nx = line_q + LINE_W'(1);
        else                                 line_nx = line_q;
        unique case (mode)
            TE_MODE_LINE: hit = (evt.hs || evt.vs) && (line_nx == target);
            TE_MODE_VS:   hit = evt.vs;
            default:      hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            line_q <= '0;
            match  <= 1'b0;
        end else begin
            line_q <= line_nx;
            match  <= hit;
        end
    end

    // R3
    vs_clears_line_chk: assert property (@(posedge clk) disable iff (rst)
        evt.vs |=> (line_q == '0));

    // R4
    hs_advances_line_chk: assert property (@(posedge clk) disable iff (rst)
        (en && evt.hs && !evt.vs && line_q != LINE_MAX) |=> (line_q == $past(line_q) + LINE_W'(1)));

    // R6
    vs_mode_fires_chk: assert property (@(posedge clk) disable iff (rst)
        (en && mode == TE_MODE_VS && evt.vs) |=> match);

    // R8
    off_mode_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == TE_MODE_OFF || mode == TE_MODE_RSVD) |=> !match);

    // R9
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !match);

    // R10
    match_single_chk: assert property (@(posedge clk) disable iff (rst)
        match |=> !match);

endmodule

// File: rtl/tesync_detector.sv
module tesync_detector
    import tesync_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                te_en,
    input  logic [1:0]          te_mode,
    input  logic [LINE_W-1:0]   te_line,
    input  logic [HS_CFG_W-1:0] hs_width_cfg,
    input  logic [VS_CFG_W-1:0] vs_width_cfg,
    input  logic                hs_invert,
    input  logic                vs_invert,
    input  logic                te_pin,
    output logic                match_o
);
    logic      pin_s;
    logic [1:0] inv_vec;
    run_meas_t meas [2];
    sync_evt_t evt;

    assign inv_vec = {vs_invert, hs_invert};

    tesync_input_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (te_pin),
        .q   (pin_s)
    );

    // index 0 measures horizontal polarity, index 1 vertical polarity
    generate
        for (genvar g = 0; g < 2; g++) begin : g_meter
            tesync_run_meter u_meter (
                .clk   (clk),
                .rst   (rst),
                .clr   (!te_en),
                .level (pin_s ^ inv_vec[g]),
                .meas  (meas[g])
            );
        end
    endgenerate

    tesync_classifier u_class (
        .hs_meas (meas[0]),
        .vs_meas (meas[1]),
        .hs_cfg  (hs_width_cfg),
        .vs_cfg  (vs_width_cfg),
        .evt     (evt)
    );

    tesync_line_tracker u_track (
        .clk    (clk),
        .rst    (rst),
        .en     (te_en),
        .mode   (te_mode_e'(te_mode)),
        .target (te_line),
        .evt    (evt),
        .match  (match_o)
    );

endmodule

// File: tb/tb_tesync_detector.sv
module tb_tesync_detector;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        te_en = 1'b0;
    logic [1:0]  te_mode = 2'b00;
    logic [10:0] te_line = '0;
    logic [2:0]  hs_width_cfg = 3'd1;
    logic [11:0] vs_width_cfg = 12'd1;
    logic        hs_invert = 1'b0;
    logic        vs_invert = 1'b0;
    logic        te_pin = 1'b0;
    logic        match_o;

    int n_checks = 0;
    int n_fail = 0;
    int mcnt = 0;
    int dbl = 0;
    logic prev_m = 1'b0;
    logic idle_lvl = 1'b0;
    bit finished = 0;

    always #4 clk = ~clk;

    tesync_detector dut (
        .clk(clk), .rst(rst), .te_en(te_en), .te_mode(te_mode), .te_line(te_line),
        .hs_width_cfg(hs_width_cfg), .vs_width_cfg(vs_width_cfg),
        .hs_invert(hs_invert), .vs_invert(vs_invert), .te_pin(te_pin), .match_o(match_o)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (match_o) mcnt++;
            if (match_o && prev_m) dbl++;
            prev_m <= match_o;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic setup(input logic [1:0] mode, input int line, input int hc,
                         input int vc, input logic inv);
        @(negedge clk);
        te_en = 1'b0;
        te_mode = mode;
        te_line = 11'(line);
        hs_width_cfg = 3'(hc);
        vs_width_cfg = 12'(vc);
        hs_invert = inv;
        vs_invert = inv;
        idle_lvl = inv;
        te_pin = inv;
        repeat (5) @(negedge clk);
        te_en = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse(input int w, input int gap);
        te_pin = ~idle_lvl;
        repeat (w) @(negedge clk);
        te_pin = idle_lvl;
        repeat (gap) @(negedge clk);
    endtask

    task automatic settle();
        repeat (10) @(negedge clk);
    endtask

    int m0;

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset", int'(match_o), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 after reset", mcnt, 0);

        // R3 R6: vertical-only width sweep, VS threshold 16 ticks
        for (int w = 1; w <= 20; w++) begin
            setup(2'b11, 0, 1, 1, 1'b0);
            m0 = mcnt;
            pulse(w, 4);
            settle();
            check("R3 R6 vs sweep", mcnt - m0, (w >= 16) ? 1 : 0);
        end

        // R2 R4 R7: line match on line 1, classification sweep
        for (int w = 1; w <= 20; w++) begin
            setup(2'b10, 1, 1, 1, 1'b0);
            pulse(20, 4);
            m0 = mcnt;
            pulse(w, 4);
            settle();
            check("R2 R4 hs sweep", mcnt - m0, (w >= 2 && w < 16) ? 1 : 0);
        end

        // R7: target lines 0..4 after one VS and three HS
        for (int t = 0; t <= 4; t++) begin
            setup(2'b10, t, 1, 1, 1'b0);
            m0 = mcnt;
            pulse(20, 4);
            for (int k = 0; k < 3; k++) pulse(4, 4);
            settle();
            check("R7 line target", mcnt - m0, (t <= 3) ? 1 : 0);
        end

        // R2 R3 R4: boundaries with HS 8 ticks, VS 24 ticks
        begin
            int ws[4] = '{7, 8, 23, 24};
            int el[4] = '{0, 1, 1, 0};
            int ev[4] = '{0, 0, 0, 1};
            for (int i = 0; i < 4; i++) begin
                setup(2'b10, 1, 7, 2, 1'b0);
                pulse(30, 4);
                m0 = mcnt;
                pulse(ws[i], 4);
                settle();
                check("R2 R4 boundary line", mcnt - m0, el[i]);
                setup(2'b11, 0, 7, 2, 1'b0);
                m0 = mcnt;
                pulse(ws[i], 4);
                settle();
                check("R3 boundary vs", mcnt - m0, ev[i]);
            end
        end

        // R5: inverted polarity, active-low pulses
        for (int w = 14; w <= 18; w++) begin
            setup(2'b11, 0, 1, 1, 1'b1);
            m0 = mcnt;
            pulse(w, 4);
            settle();
            check("R5 inverted vs", mcnt - m0, (w >= 16) ? 1 : 0);
        end
        setup(2'b10, 2, 1, 1, 1'b1);
        m0 = mcnt;
        pulse(20, 4); pulse(3, 4); pulse(3, 4);
        settle();
        check("R5 inverted line", mcnt - m0, 1);

        // R6: HS pulses alone in vertical-only mode, then three VS
        setup(2'b11, 0, 1, 1, 1'b0);
        m0 = mcnt;
        for (int k = 0; k < 5; k++) pulse(4, 4);
        settle();
        check("R6 hs ignored", mcnt - m0, 0);
        m0 = mcnt;
        for (int k = 0; k < 3; k++) pulse(18, 6);
        settle();
        check("R6 three vs", mcnt - m0, 3);

        // R8: off and reserved modes
        for (int md = 0; md < 2; md++) begin
            setup(2'(md), 0, 1, 1, 1'b0);
            m0 = mcnt;
            pulse(20, 4); pulse(4, 4); pulse(20, 4);
            settle();
            check("R8 mode off", mcnt - m0, 0);
        end

        // R9: pulse while disabled
        setup(2'b11, 0, 1, 1, 1'b0);
        m0 = mcnt;
        te_en = 1'b0;
        pulse(20, 6);
        te_en = 1'b1;
        settle();
        check("R9 disabled pulse", mcnt - m0, 0);

        // R9: disable clears line count (control: without disable it matches)
        setup(2'b10, 2, 1, 1, 1'b0);
        m0 = mcnt;
        pulse(20, 4); pulse(4, 4); pulse(4, 4);
        settle();
        check("R9 control", mcnt - m0, 1);
        setup(2'b10, 2, 1, 1, 1'b0);
        m0 = mcnt;
        pulse(20, 4); pulse(4, 4);
        te_en = 1'b0;
        repeat (3) @(negedge clk);
        te_en = 1'b1;
        repeat (2) @(negedge clk);
        pulse(4, 4);
        settle();
        check("R9 cleared line", mcnt - m0, 0);

        // R10: no strobe ever lasted two cycles
        check("R10 single cycle", dbl, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule